// File: doc/BRIEF.md
# Tiled Matrix Transpose Sequencer

The block copies an N-row by M-column matrix of 32-bit words from a source area to a destination area of one single-ported word memory and leaves the transpose behind. Both areas are row-major: the source has M words per row and the destination has N words per row. Element (r,c) of the source ends up at element (c,r) of the destination. The work is done tile by tile. At most eight words are kept in a local register bank between the reads and the writes. The block issues at most one memory operation per cycle, and read data returns on the following cycle.

The tiling scheme is chosen when the block starts, from the two dimensions.

- **Both dimensions equal 64:** each 8x8 tile is handled as four 4x4 quadrants in two phases. The first phase transposes the top-left quadrant into place. It also parks the source top-right quadrant in the destination top-right quadrant. The second phase swaps the parked words with the bottom-left data and places the bottom-right quadrant.
- **Other square power-of-two sizes:** plain 8x8 tiles are used.
- **All other sizes:** clipped 16x16 tiles are used. The tile loops stop at the matrix edges.

Top module: `mtx_transpose_seq`

## Requirements
- R1: After a run, destination word at address dst_base + c*N + r holds the source word that was at src_base + r*M + c, for every r < N and c < M.
- R2: Ragged edges are clipped. Every write lands in [dst_base, dst_base + N*M). Every read lands either in that window or in [src_base, src_base + N*M). The source is never written.
- R3: Mode choice:
  - When N = M = 64, the quadrant schedule is used.
  - Otherwise, when N = M and N is a power of two (1 included), 8x8 plain tiles are used.
  - Otherwise, 16x16 plain tiles are used.
- R4: In the plain modes, each tile row is moved in chunks of up to eight words: the chunk is read left to right, then written down one destination column. A run then costs exactly 2*N*M operations, N*M of them writes, and it never reads the destination.
- R5: In the quadrant schedule, each 8x8 tile costs 160 operations: 80 writes and 80 reads, 16 of the reads from the destination area. A 64x64 run therefore costs 10240 operations, 5120 writes and 1024 destination reads.
- R6: At most one operation is issued per cycle. mem_we is high only with mem_req. Read data is taken from mem_rdata in the cycle after the read. This includes a chunk of one word, which is written in the very next cycle.
- R7: busy is high from the cycle after an accepted start through the last operation. done is high for exactly one cycle, the cycle right after the last write.
- R8: start is accepted only while idle. A start pulse during a run, even with other dimensions, changes neither the operation count nor the result.
- R9: When N or M is zero, no memory operation is issued and done pulses in the cycle after start.
- R10: Tiles are visited with the source row-block as the outer loop and the column-block as the inner loop. The first read of the second tile is therefore source (0, tile width).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transpose (taken only while idle) |
| rows_n | input | DIMW | Source row count N |
| cols_m | input | DIMW | Source column count M |
| src_base | input | AW | Word address of source element (0,0) |
| dst_base | input | AW | Word address of destination element (0,0) |
| mem_req | output | 1 | Memory operation valid this cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Word address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, one cycle after the read |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The cases cover 32x32, 64x64, 61x67, 16x16, 5x3, 1x1 and 0x7 matrices, and every destination word is compared with a transpose computed in the bench.

- **Telling the schedules apart:** the count of reads that hit the destination area separates the quadrant schedule from plain tiling.
- **Telling the tile sizes apart:** the address of the read that opens the second tile separates 8-wide from 16-wide tiles and row-major from column-major tile order. The 16x16 case exists to show that a square power of two other than 64 gets 8x8 tiles.
- **Edge cases:** 61x67 and 5x3 exercise clipping on both edges. 1x1 exercises a read followed at once by a write of the same register. 0x7 exercises the empty run.
- **Start during a run:** in one 32x32 run, a second start arrives mid-run with other dimensions, and the operation count and data must be unchanged.

// File: rtl/mtxt_pkg.sv
package mtxt_pkg;

  typedef enum logic [1:0] {
    MODE_QUAD,
    MODE_TILE8,
    MODE_TILE16
  } tile_mode_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_P_RD,
    ST_P_WR,
    ST_Q1_RD,
    ST_Q1_WR,
    ST_Q2_RDL,
    ST_Q2_RDP,
    ST_Q2_WRL,
    ST_Q2_RDR,
    ST_Q2_WRP,
    ST_Q2_WRR,
    ST_DONE
  } seq_state_e;

  function automatic logic is_pow2(input int unsigned x);
    return (x != 0) && ((x & (x - 1)) == 0);
  endfunction

endpackage

// File: rtl/mtxt_mode_pick.sv
module mtxt_mode_pick
  import mtxt_pkg::*;
#(
  parameter int DIMW       = 8,
  parameter int QUAD_DIM   = 64,
  parameter int SMALL_TILE = 8,
  parameter int LARGE_TILE = 16,
  parameter int TW         = 5
) (
  input  logic [DIMW-1:0] dim_n,
  input  logic [DIMW-1:0] dim_m,
  output tile_mode_e      mode,
  output logic [TW-1:0]   tile_sz
);

  logic square_dims;
  logic quad_dims;

  assign square_dims = (dim_n == dim_m);
  assign quad_dims   = square_dims && (dim_n == DIMW'(QUAD_DIM));

  always_comb begin
    if (quad_dims) begin
      mode    = MODE_QUAD;
      tile_sz = TW'(SMALL_TILE);
    end else if (square_dims && is_pow2(int'(dim_n))) begin
      mode    = MODE_TILE8;
      tile_sz = TW'(SMALL_TILE);
    end else begin
      mode    = MODE_TILE16;
      tile_sz = TW'(LARGE_TILE);
    end
  end

endmodule

// File: rtl/mtxt_word_bank.sv
module mtxt_word_bank #(
  parameter int DW    = 32,
  parameter int NSLOT = 8,
  parameter int SW    = $clog2(NSLOT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_en,
  input  logic [SW-1:0] cap_slot,
  input  logic [DW-1:0] cap_data,
  input  logic [SW-1:0] rd_slot,
  output logic [DW-1:0] rd_data
);

  logic [DW-1:0] slot_q [NSLOT];
  logic          fwd_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int g = 0; g < NSLOT; g++) slot_q[g] <= '0;
    end else if (cap_en) begin
      slot_q[cap_slot] <= cap_data;
    end
  end

  // A word read in the previous cycle is not yet in its slot: pass it through.
  assign fwd_hit = cap_en && (cap_slot == rd_slot);
  assign rd_data = fwd_hit ? cap_data : slot_q[rd_slot];

endmodule

// File: rtl/mtxt_addr_gen.sv
module mtxt_addr_gen
  import mtxt_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DIMW  = 8,
  parameter int TW    = 5,
  parameter int NSLOT = 8,
  parameter int SW    = $clog2(NSLOT)
) (
  input  seq_state_e      st,
  input  logic [DIMW-1:0] ti,
  input  logic [DIMW-1:0] tj,
  input  logic [TW-1:0]   rr,
  input  logic [TW-1:0]   cc,
  input  logic [1:0]      kk,
  input  logic [SW-1:0]   s,
  input  logic [DIMW-1:0] n,
  input  logic [DIMW-1:0] m,
  input  logic [AW-1:0]   src,
  input  logic [AW-1:0]   dst,
  output logic            req,
  output logic            we,
  output logic [AW-1:0]   addr,
  output logic [SW-1:0]   slot
);

  localparam int HALF = NSLOT / 2;

  function automatic logic [AW-1:0] rm_addr(input logic [AW-1:0] b, input logic [AW-1:0] row,
                                            input logic [AW-1:0] col, input logic [AW-1:0] wid);
    return b + row * wid + col;
  endfunction

  logic [AW-1:0] i_w, j_w, k_w, s_w, s_lo, rr_w, cc_w, half_w;
  logic [AW-1:0] base, row, col, wid;
  logic [SW-1:0] slot_hi;

  assign i_w     = AW'(ti);
  assign j_w     = AW'(tj);
  assign k_w     = AW'(kk);
  assign s_w     = AW'(s);
  assign s_lo    = s_w & AW'(HALF - 1);
  assign rr_w    = AW'(rr);
  assign cc_w    = AW'(cc);
  assign half_w  = AW'(HALF);
  assign slot_hi = SW'(HALF) + SW'(s_lo);

  always_comb begin
    req  = 1'b1;
    we   = 1'b0;
    base = src;
    wid  = AW'(m);
    row  = '0;
    col  = '0;
    slot = s;
    case (st)
      ST_P_RD: begin
        row = i_w + rr_w;
        col = j_w + cc_w + s_w;
      end
      ST_P_WR: begin
        we = 1'b1; base = dst; wid = AW'(n);
        row = j_w + cc_w + s_w;
        col = i_w + rr_w;
      end
      ST_Q1_RD: begin
        row = i_w + k_w;
        col = j_w + s_w;
      end
      ST_Q1_WR: begin
        we = 1'b1; base = dst; wid = AW'(n);
        row = j_w + s_lo;
        col = i_w + k_w + ((s_w >= half_w) ? half_w : '0);
      end
      ST_Q2_RDL: begin
        row = i_w + half_w + s_lo;
        col = j_w + k_w;
      end
      ST_Q2_RDP: begin
        base = dst; wid = AW'(n);
        row = j_w + k_w;
        col = i_w + half_w + s_lo;
        slot = slot_hi;
      end
      ST_Q2_WRL: begin
        we = 1'b1; base = dst; wid = AW'(n);
        row = j_w + k_w;
        col = i_w + half_w + s_lo;
      end
      ST_Q2_RDR: begin
        row = i_w + half_w + s_lo;
        col = j_w + k_w + half_w;
      end
      ST_Q2_WRP: begin
        we = 1'b1; base = dst; wid = AW'(n);
        row = j_w + k_w + half_w;
        col = i_w + s_lo;
        slot = slot_hi;
      end
      ST_Q2_WRR: begin
        we = 1'b1; base = dst; wid = AW'(n);
        row = j_w + k_w + half_w;
        col = i_w + half_w + s_lo;
      end
      default: req = 1'b0;
    endcase
    addr = req ? rm_addr(base, row, col, wid) : '0;
  end

endmodule

// File: rtl/mtx_transpose_seq.sv
module mtx_transpose_seq
  import mtxt_pkg::*;
#(
  parameter int AW         = 16,
  parameter int DW         = 32,
  parameter int DIMW       = 8,
  parameter int QUAD_DIM   = 64,
  parameter int SMALL_TILE = 8,
  parameter int LARGE_TILE = 16,
  parameter int NSLOT      = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [DIMW-1:0] rows_n,
  input  logic [DIMW-1:0] cols_m,
  input  logic [AW-1:0]   src_base,
  input  logic [AW-1:0]   dst_base,
  output logic            mem_req,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic [DW-1:0]   mem_rdata,
  output logic            busy,
  output logic            done
);

  localparam int SW   = $clog2(NSLOT);
  localparam int TW   = $clog2(LARGE_TILE) + 1;
  localparam int XW   = DIMW + 2;
  localparam int HALF = NSLOT / 2;

  seq_state_e      st;
  tile_mode_e      mode_q, pick_mode;
  logic [TW-1:0]   tsz_q, pick_tsz;
  logic [DIMW-1:0] n_q, m_q, ti, tj;
  logic [AW-1:0]   src_q, dst_q;
  logic [TW-1:0]   rr, cc;
  logic [1:0]      kk;
  logic [SW-1:0]   s;
  logic            rd_pend;
  logic [SW-1:0]   rd_slot_q;

  logic            ag_req, ag_we;
  logic [AW-1:0]   ag_addr;
  logic [SW-1:0]   ag_slot;

  // Named events used by the sequencing and by the assertions
  logic [XW-1:0]   col_base, rem_m, rem_t, chunk_len;
  logic            p_last_s, more_chunk, more_row, more_tcol, more_trow;
  logic            q_last_full, q_last_half, tile_end, zero_dim, start_take;
  seq_state_e      first_st;
  logic [AW-1:0]   dst_span, src_span;

  mtxt_mode_pick #(
    .DIMW(DIMW), .QUAD_DIM(QUAD_DIM), .SMALL_TILE(SMALL_TILE),
    .LARGE_TILE(LARGE_TILE), .TW(TW)
  ) u_pick (
    .dim_n(rows_n), .dim_m(cols_m), .mode(pick_mode), .tile_sz(pick_tsz)
  );

  mtxt_addr_gen #(
    .AW(AW), .DIMW(DIMW), .TW(TW), .NSLOT(NSLOT), .SW(SW)
  ) u_agen (
    .st(st), .ti(ti), .tj(tj), .rr(rr), .cc(cc), .kk(kk), .s(s),
    .n(n_q), .m(m_q), .src(src_q), .dst(dst_q),
    .req(ag_req), .we(ag_we), .addr(ag_addr), .slot(ag_slot)
  );

  mtxt_word_bank #(
    .DW(DW), .NSLOT(NSLOT), .SW(SW)
  ) u_bank (
    .clk(clk), .rst_n(rst_n),
    .cap_en(rd_pend), .cap_slot(rd_slot_q), .cap_data(mem_rdata),
    .rd_slot(ag_slot), .rd_data(mem_wdata)
  );

  assign mem_req  = ag_req;
  assign mem_we   = ag_we;
  assign mem_addr = ag_addr;
  assign busy     = (st != ST_IDLE) && (st != ST_DONE);
  assign done     = (st == ST_DONE);

  assign col_base    = XW'(tj) + XW'(cc);
  assign rem_m       = XW'(m_q) - col_base;
  assign rem_t       = XW'(tsz_q) - XW'(cc);
  always_comb begin
    chunk_len = XW'(NSLOT);
    if (rem_t < chunk_len) chunk_len = rem_t;
    if (rem_m < chunk_len) chunk_len = rem_m;
  end
  assign p_last_s    = (XW'(s) + XW'(1)) == chunk_len;
  assign more_chunk  = (XW'(cc) + XW'(NSLOT) < XW'(tsz_q)) && (col_base + XW'(NSLOT) < XW'(m_q));
  assign more_row    = (XW'(rr) + XW'(1) < XW'(tsz_q)) && (XW'(ti) + XW'(rr) + XW'(1) < XW'(n_q));
  assign more_tcol   = XW'(tj) + XW'(tsz_q) < XW'(m_q);
  assign more_trow   = XW'(ti) + XW'(tsz_q) < XW'(n_q);
  assign q_last_full = (s == SW'(NSLOT - 1));
  assign q_last_half = (s == SW'(HALF - 1));
  assign tile_end    = ((st == ST_P_WR) && p_last_s && !more_chunk && !more_row) ||
                       ((st == ST_Q2_WRR) && q_last_half && (kk == 2'd3));
  assign zero_dim    = (rows_n == '0) || (cols_m == '0);
  assign start_take  = (st == ST_IDLE) && start;
  assign first_st    = (mode_q == MODE_QUAD) ? ST_Q1_RD : ST_P_RD;
  assign dst_span    = AW'(n_q) * AW'(m_q);
  assign src_span    = dst_span;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; mode_q <= MODE_TILE16; tsz_q <= '0;
      n_q <= '0; m_q <= '0; src_q <= '0; dst_q <= '0;
      ti <= '0; tj <= '0; rr <= '0; cc <= '0; kk <= '0; s <= '0;
      rd_pend <= 1'b0; rd_slot_q <= '0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          n_q <= rows_n; m_q <= cols_m; src_q <= src_base; dst_q <= dst_base;
          mode_q <= pick_mode; tsz_q <= pick_tsz;
          ti <= '0; tj <= '0; rr <= '0; cc <= '0; kk <= '0; s <= '0;
          if (zero_dim)                    st <= ST_DONE;
          else if (pick_mode == MODE_QUAD) st <= ST_Q1_RD;
          else                             st <= ST_P_RD;
        end
        ST_P_RD: if (p_last_s) begin s <= '0; st <= ST_P_WR; end
                 else s <= s + SW'(1);
        ST_P_WR: if (p_last_s) begin
          s <= '0;
          if (more_chunk) begin
            cc <= cc + TW'(NSLOT); st <= ST_P_RD;
          end else begin
            cc <= '0;
            if (more_row) begin rr <= rr + TW'(1); st <= ST_P_RD; end
            else rr <= '0;
          end
        end else s <= s + SW'(1);
        ST_Q1_RD: if (q_last_full) begin s <= '0; st <= ST_Q1_WR; end
                  else s <= s + SW'(1);
        ST_Q1_WR: if (q_last_full) begin
          s <= '0;
          if (kk == 2'd3) begin kk <= '0; st <= ST_Q2_RDL; end
          else begin kk <= kk + 2'd1; st <= ST_Q1_RD; end
        end else s <= s + SW'(1);
        ST_Q2_RDL: if (q_last_half) begin s <= '0; st <= ST_Q2_RDP; end
                   else s <= s + SW'(1);
        ST_Q2_RDP: if (q_last_half) begin s <= '0; st <= ST_Q2_WRL; end
                   else s <= s + SW'(1);
        ST_Q2_WRL: if (q_last_half) begin s <= '0; st <= ST_Q2_RDR; end
                   else s <= s + SW'(1);
        ST_Q2_RDR: if (q_last_half) begin s <= '0; st <= ST_Q2_WRP; end
                   else s <= s + SW'(1);
        ST_Q2_WRP: if (q_last_half) begin s <= '0; st <= ST_Q2_WRR; end
                   else s <= s + SW'(1);
        ST_Q2_WRR: if (q_last_half) begin
          s <= '0;
          if (kk == 2'd3) kk <= '0;
          else begin kk <= kk + 2'd1; st <= ST_Q2_RDL; end
        end else s <= s + SW'(1);
        ST_DONE: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase

      // Tile walk: column-block inner, row-block outer
      if (tile_end) begin
        if (more_tcol) begin
          tj <= tj + DIMW'(tsz_q); st <= first_st;
        end else begin
          tj <= '0;
          if (more_trow) begin ti <= ti + DIMW'(tsz_q); st <= first_st; end
          else st <= ST_DONE;
        end
      end

      rd_pend   <= ag_req && !ag_we;
      rd_slot_q <= ag_slot;
    end
  end

  // R6: a write is always a memory operation
  assert_we_with_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_req);

  // R7: done lasts one cycle and carries no operation
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_req && !busy);

  // R8: a start during a run leaves the latched job alone
  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(n_q) && $stable(m_q) && $stable(dst_q) && $stable(src_q));

  // R2: writes stay inside the destination window
  assert_write_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> ((mem_addr - dst_q) < dst_span));

  // R2: reads stay inside the source or destination window
  assert_read_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |-> (((mem_addr - src_q) < src_span) || ((mem_addr - dst_q) < dst_span)));

  // R4: plain tiling never reads the destination window
  assert_plain_no_dst_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && (mode_q != MODE_QUAD)) |-> ((mem_addr - src_q) < src_span));

  // R3: the quadrant schedule runs only on the 64 by 64 job
  assert_quad_only_square_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (mode_q == MODE_QUAD)) |-> (n_q == DIMW'(QUAD_DIM)) && (m_q == DIMW'(QUAD_DIM)));

endmodule

// File: tb/tb_mtx_transpose_seq.sv
`timescale 1ns/1ps
module tb_mtx_transpose_seq;

  localparam int AW = 16, DW = 32, DIMW = 8;
  localparam int MEMW = 14;
  localparam int DST = 8192;
  localparam int LIMIT = 30000;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [DIMW-1:0] rows_n = '0, cols_m = '0;
  logic [AW-1:0] src_base = '0, dst_base = AW'(DST);
  logic mem_req, mem_we, busy, done;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;

  logic [DW-1:0] mem [0:(1<<MEMW)-1];

  typedef struct { int unsigned addr; logic [DW-1:0] val; } exp_t;
  exp_t exp_q[$];

  int n_checks = 0, n_errs = 0;
  int cyc = 0, ops = 0, wrs = 0, dst_rd = 0, src_wr = 0, oor = 0;
  int rd_seen = 0, probe_target = -1, probe_addr = -1;
  int last_wr_cyc = 0, done_cyc = 0, done_cnt = 0;
  int cur_n = 0, cur_m = 0;

  always #2.5 clk = ~clk;

  mtx_transpose_seq dut (
    .clk(clk), .rst_n(rst_n), .start(start), .rows_n(rows_n), .cols_m(cols_m),
    .src_base(src_base), .dst_base(dst_base), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .busy(busy), .done(done)
  );

  // Memory model: one-cycle read latency
  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) mem[mem_addr[MEMW-1:0]] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr[MEMW-1:0]];
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Operation monitor
  always @(negedge clk) begin
    int a;
    cyc++;
    a = int'(mem_addr);
    if (mem_req) begin
      ops++;
      if (mem_we) begin
        wrs++; last_wr_cyc = cyc;
        if (a < DST) src_wr++;
        if (a < DST || a >= DST + cur_n*cur_m) oor++;
      end else begin
        if (a >= DST) dst_rd++;
        if (!(a < cur_n*cur_m || (a >= DST && a < DST + cur_n*cur_m))) oor++;
        if (rd_seen == probe_target) probe_addr = a;
        rd_seen++;
      end
    end
    if (done) begin done_cnt++; done_cyc = cyc; end
  end

  // Scoreboard monitor: pops expected destination words and compares
  always @(negedge clk) begin
    while (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      n_checks++;
      if (mem[e.addr] !== e.val) begin
        n_errs++;
        $display("FAIL R1 dst[%0d] actual=%h expected=%h", e.addr, mem[e.addr], e.val);
      end
    end
  end

  function automatic logic [DW-1:0] src_val(input int id, input int r, input int c);
    return {id[7:0], r[11:0], c[11:0]};
  endfunction

  task automatic run_case(input int id, input int n, input int m, input int e_ops,
                          input int e_wr, input int e_drd, input int p_idx,
                          input int e_probe, input bit poke, input string tag);
    int ops0, wr0, drd0, swr0, oor0, dc0, waited;
    for (int r = 0; r < n; r++)
      for (int c = 0; c < m; c++) mem[r*m + c] = src_val(id, r, c);
    for (int k = DST; k < (1<<MEMW); k++) mem[k] = 32'hDEAD_BEEF;
    @(negedge clk);
    cur_n = n; cur_m = m;
    ops0 = ops; wr0 = wrs; drd0 = dst_rd; swr0 = src_wr; oor0 = oor; dc0 = done_cnt;
    probe_target = (p_idx >= 0) ? rd_seen + p_idx : -1;
    probe_addr = -1;
    rows_n = DIMW'(n); cols_m = DIMW'(m); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (n*m > 0) chk(busy == 1'b1, {"R7 busy after start ", tag}, busy, 1);
    else         chk(done == 1'b1, {"R9 done after empty start ", tag}, done, 1);
    waited = 0;
    while (done_cnt == dc0 && waited < LIMIT) begin
      @(negedge clk);
      waited++;
      if (poke && waited == 100) begin rows_n = 8'd3; cols_m = 8'd5; start = 1'b1; end
      if (poke && waited == 101) start = 1'b0;
    end
    chk(waited < LIMIT, {"R7 run finished ", tag}, waited, 0);
    repeat (3) @(negedge clk);
    chk(done_cnt - dc0 == 1, {"R7 single done pulse ", tag}, done_cnt - dc0, 1);
    chk(ops - ops0 == e_ops, {"R4 R5 R8 op count ", tag}, ops - ops0, e_ops);
    chk(wrs - wr0 == e_wr, {"R4 R5 write count ", tag}, wrs - wr0, e_wr);
    chk(dst_rd - drd0 == e_drd, {"R3 R5 destination reads ", tag}, dst_rd - drd0, e_drd);
    chk(src_wr - swr0 == 0, {"R2 source untouched ", tag}, src_wr - swr0, 0);
    chk(oor - oor0 == 0, {"R2 accesses in window ", tag}, oor - oor0, 0);
    if (n*m > 0)
      chk(done_cyc == last_wr_cyc + 1, {"R7 done after last write ", tag}, done_cyc, last_wr_cyc + 1);
    if (p_idx >= 0)
      chk(probe_addr == e_probe, {"R10 R3 second tile first read ", tag}, probe_addr, e_probe);
    // Expected transpose, pushed to the scoreboard
    for (int r = 0; r < n; r++)
      for (int c = 0; c < m; c++) begin
        exp_t e;
        e.addr = DST + c*n + r;
        e.val  = src_val(id, r, c);
        exp_q.push_back(e);
      end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R7 reset busy", busy, 0);
    chk(done == 1'b0, "R7 reset done", done, 0);
    chk(mem_req == 1'b0, "R6 reset no request", mem_req, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // 32x32: 8x8 plain tiles, second tile opens at source (0,8)
    run_case(1, 32, 32, 2048, 1024, 0, 64, 8, 1'b0, "32x32");
    // 64x64: quadrant schedule, 80 reads per tile, second tile at (0,8)
    run_case(2, 64, 64, 10240, 5120, 1024, 80, 8, 1'b0, "64x64");
    // 61x67: clipped 16x16 tiles, second tile at (0,16)
    run_case(3, 61, 67, 8174, 4087, 0, 256, 16, 1'b0, "61x67");
    // 16x16: square power of two, 8x8 tiles (16 wide would give address 64)
    run_case(4, 16, 16, 512, 256, 0, 64, 8, 1'b0, "16x16");
    run_case(5, 5, 3, 30, 15, 0, -1, 0, 1'b0, "5x3 ragged");
    run_case(6, 1, 1, 2, 1, 0, -1, 0, 1'b0, "1x1 R6 forward");
    run_case(7, 0, 7, 0, 0, 0, -1, 0, 1'b0, "0x7 R9");
    // R8: second start mid-run with other dimensions
    run_case(8, 32, 32, 2048, 1024, 0, 64, 8, 1'b1, "32x32 R8 restart");
    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_errs++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

endmodule